// File: doc/BRIEF.md
# Flash Page Program-Verify Sequencer

This block programs one page of a flash array through a loop of program pulses and verify reads. While idle, a host loads target bytes into a page buffer and then pulses a start strobe with a page-aligned address. The block copies the targets into a second buffer, called the retry buffer. It writes that buffer into the flash byte latches and drives the setup, program and verify strobes in a fixed order, using timed gaps between them. In verify mode it reads the page back one word at a time.

After each read-back, the retry buffer is rewritten from the target and the read-back value. A bit is pulsed again only if its target is 0 and it still reads 1. The loop ends with done when every word matches its target. It ends with fail when the attempt limit is used up without a match. A misaligned start address is refused immediately with fail. Every wait length and the attempt limit are parameters counted in clock cycles, and one shared down-counter times all of them.

Top module: `fpv_seq`

## Requirements
- R1: A start while idle whose address has any of its low log2(PAGE_BYTES) bits set raises fail from the next cycle. Busy stays low, and no flash strobe is driven.
- R2: An accepted start raises busy from the next cycle, and write-enable stays high for the whole operation. From that same cycle, each pass begins with PAGE_BYTES latch writes, one per cycle, at base+0 up to base+PAGE_BYTES-1 in ascending order.
- R3: In the first pass, byte positions loaded since the previous accepted start are latched with their loaded values. All other positions are latched as 0xFF.
- R4: In each pass, setup is high for T_SETUP cycles before program rises. Program stays high for exactly T_PROG cycles and only while setup and write-enable are high. Verify is never high together with setup or program.
- R5: In each verify phase, the block handles every word of the page in ascending order. For each word it makes a byte write of 0xFF at the word's even address, then a read of that address. Read data arrives one cycle after the read strobe, and its low byte belongs to the even address.
- R6: Each later pass latches, for every byte, the target OR the inverted read-back. A bit that reads 0, or whose target is 1, therefore gets no further pulse.
- R7: When every word read back equals its target, done rises and busy and write-enable fall. The number of program pulses equals the number of passes the slowest bit needed.
- R8: If MAX_TRIES pulses have been given without a full match, fail rises, write-enable falls and no further pulse follows.
- R9: While busy, host byte writes and start pulses have no effect.
- R10: After reset, busy, done and fail are low. Done and fail hold until the next accepted start, which clears both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, sampled while idle |
| page_addr | input | ADDR_W | Page start address |
| host_we | input | 1 | Host byte write into the page buffer |
| host_idx | input | log2(PAGE_BYTES) | Byte position for host_we |
| host_data | input | 8 | Byte value for host_we |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last operation succeeded |
| fail | output | 1 | Last operation failed or was refused |
| fl_we | output | 1 | Flash write-enable |
| fl_setup | output | 1 | Flash program setup strobe |
| fl_prog | output | 1 | Flash program pulse |
| fl_verify | output | 1 | Flash verify mode |
| fl_wr | output | 1 | Flash byte write (latch load or dummy write) |
| fl_rd | output | 1 | Flash word read |
| fl_addr | output | ADDR_W | Flash byte address |
| fl_wdata | output | 8 | Flash write byte |
| fl_rdata | input | 16 | Flash read word, valid one cycle after fl_rd |

## Verification
Fail for a refused start, and busy together with the first latch write, are due one clock edge after start is sampled. The bench therefore drives start on a falling edge and checks those outputs on the next falling edge. The flash model answers a read one edge later, matching the one-cycle latency the sequencer expects. It counts pulse widths and setup lead in cycles on rising edges. Results that only appear at the end of the loop (done, fail, buffer contents per pass, pulse counts) are checked on falling edges, after busy has been seen low.

// File: rtl/fpv_pkg.sv
package fpv_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_LOAD,
      S_SETUP,
      S_PROG,
      S_PHOLD,
      S_SHOLD,
      S_VON,
      S_DWR,
      S_DWAIT,
      S_RD,
      S_CAP,
      S_VOFF
   } fpv_state_e;

   typedef struct packed {
      logic we;
      logic setup;
      logic prog;
      logic verify;
      logic wr;
      logic rd;
   } fpv_strobe_t;

   function automatic int fpv_max(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/fpv_timer.sv
module fpv_timer #(
   parameter int CNT_W = 4
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/fpv_buf.sv
module fpv_buf #(
   parameter int PAGE_BYTES = 32,
   localparam int IDX_W  = $clog2(PAGE_BYTES),
   localparam int WIDX_W = IDX_W - 1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [7:0]        host_data,
   input  logic              init,
   input  logic              upd,
   input  logic [WIDX_W-1:0] upd_widx,
   input  logic [15:0]       rdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [7:0]        rp_byte,
   output logic              word_match
);

   logic [7:0]            tgt_q   [PAGE_BYTES];
   logic [7:0]            rp_q    [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] vld_q;
   logic [7:0]            rb_lane [PAGE_BYTES];
   logic [PAGE_BYTES-1:0] lane_hit;

   // each lane picks its half of the read word and decodes its own update
   for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_lane
      if ((g % 2) == 1) begin : g_hi
         assign rb_lane[g] = rdata[15:8];
      end else begin : g_lo
         assign rb_lane[g] = rdata[7:0];
      end
      assign lane_hit[g] = upd && (upd_widx == WIDX_W'(g / 2));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < PAGE_BYTES; i++) begin
            tgt_q[i] <= 8'hFF;
            rp_q[i]  <= 8'hFF;
         end
         vld_q <= '0;
      end else if (init) begin
         // unloaded positions become "leave erased"
         for (int i = 0; i < PAGE_BYTES; i++) begin
            tgt_q[i] <= vld_q[i] ? tgt_q[i] : 8'hFF;
            rp_q[i]  <= vld_q[i] ? tgt_q[i] : 8'hFF;
         end
         vld_q <= '0;
      end else begin
         if (host_we) begin
            tgt_q[host_idx] <= host_data;
            vld_q[host_idx] <= 1'b1;
         end
         for (int i = 0; i < PAGE_BYTES; i++) begin
            if (lane_hit[i]) begin
               rp_q[i] <= tgt_q[i] | ~rb_lane[i];
            end
         end
      end
   end

   assign rp_byte    = rp_q[rd_idx];
   assign word_match = ({tgt_q[{upd_widx, 1'b1}], tgt_q[{upd_widx, 1'b0}]} == rdata);

endmodule

// File: rtl/fpv_ctrl.sv
module fpv_ctrl
   import fpv_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 32,
   parameter int CNT_W      = 4,
   parameter int T_SETUP    = 4,
   parameter int T_PROG     = 6,
   parameter int T_PHOLD    = 2,
   parameter int T_SHOLD    = 2,
   parameter int T_VON      = 3,
   parameter int T_DUMMY    = 2,
   parameter int T_VOFF     = 2,
   parameter int MAX_TRIES  = 4,
   localparam int IDX_W  = $clog2(PAGE_BYTES),
   localparam int WIDX_W = IDX_W - 1,
   localparam int WORDS  = PAGE_BYTES / 2,
   localparam int TRY_W  = $clog2(MAX_TRIES + 1)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] page_addr,
   input  logic              tmr_expired,
   input  logic              word_match,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_val,
   output logic              buf_init,
   output logic              buf_upd,
   output logic [IDX_W-1:0]  byte_idx,
   output logic [WIDX_W-1:0] word_idx,
   output logic [ADDR_W-1:0] fl_addr,
   output fpv_strobe_t       strobe,
   output logic              busy,
   output logic              done,
   output logic              fail
);

   localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(PAGE_BYTES - 1);
   localparam logic [WIDX_W-1:0] LAST_W   = WIDX_W'(WORDS - 1);
   localparam logic [TRY_W-1:0]  TRY_LIM  = TRY_W'(MAX_TRIES);

   fpv_state_e        st_q, st_d;
   logic [ADDR_W-1:0] base_q;
   logic [IDX_W-1:0]  idx_q;
   logic [WIDX_W-1:0] widx_q;
   logic [TRY_W-1:0]  tries_q;
   logic              match_q;
   logic              done_q;
   logic              fail_q;
   logic              aligned;
   logic              idle;

   assign idle    = (st_q == S_IDLE);
   assign aligned = (page_addr[IDX_W-1:0] == '0);

   always_comb begin
      st_d     = st_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      unique case (st_q)
         S_IDLE: begin
            if (start && aligned) st_d = S_LOAD;
         end
         S_LOAD: begin
            if (idx_q == LAST_IDX) begin
               st_d     = S_SETUP;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(T_SETUP - 1);
            end
         end
         S_SETUP: begin
            if (tmr_expired) begin
               st_d     = S_PROG;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(T_PROG - 1);
            end
         end
         S_PROG: begin
            if (tmr_expired) begin
               st_d     = S_PHOLD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(T_PHOLD - 1);
            end
         end
         S_PHOLD: begin
            if (tmr_expired) begin
               st_d     = S_SHOLD;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(T_SHOLD - 1);
            end
         end
         S_SHOLD: begin
            if (tmr_expired) begin
               st_d     = S_VON;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(T_VON - 1);
            end
         end
         S_VON: begin
            if (tmr_expired) st_d = S_DWR;
         end
         S_DWR: begin
            st_d     = S_DWAIT;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(T_DUMMY - 1);
         end
         S_DWAIT: begin
            if (tmr_expired) st_d = S_RD;
         end
         S_RD: begin
            st_d = S_CAP;
         end
         S_CAP: begin
            if (widx_q == LAST_W) begin
               st_d     = S_VOFF;
               tmr_load = 1'b1;
               tmr_val  = CNT_W'(T_VOFF - 1);
            end else begin
               st_d = S_DWR;
            end
         end
         S_VOFF: begin
            if (tmr_expired) begin
               if (match_q || (tries_q == TRY_LIM)) st_d = S_IDLE;
               else                                 st_d = S_LOAD;
            end
         end
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= S_IDLE;
         base_q  <= '0;
         idx_q   <= '0;
         widx_q  <= '0;
         tries_q <= '0;
         match_q <= 1'b0;
         done_q  <= 1'b0;
         fail_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         unique case (st_q)
            S_IDLE: begin
               if (start) begin
                  done_q  <= 1'b0;
                  fail_q  <= !aligned;
                  base_q  <= page_addr;
                  idx_q   <= '0;
                  tries_q <= TRY_W'(1);
               end
            end
            S_LOAD: idx_q <= idx_q + 1'b1;
            S_VON: begin
               if (tmr_expired) begin
                  widx_q  <= '0;
                  match_q <= 1'b1;
               end
            end
            S_CAP: begin
               widx_q  <= widx_q + 1'b1;
               match_q <= match_q & word_match;
            end
            S_VOFF: begin
               if (tmr_expired) begin
                  if (match_q)                  done_q  <= 1'b1;
                  else if (tries_q == TRY_LIM)  fail_q  <= 1'b1;
                  else                          tries_q <= tries_q + 1'b1;
               end
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      strobe        = '0;
      strobe.we     = !idle;
      strobe.setup  = (st_q == S_SETUP) || (st_q == S_PROG) || (st_q == S_PHOLD);
      strobe.prog   = (st_q == S_PROG);
      strobe.verify = (st_q == S_VON) || (st_q == S_DWR) || (st_q == S_DWAIT) ||
                      (st_q == S_RD)  || (st_q == S_CAP);
      strobe.wr     = (st_q == S_LOAD) || (st_q == S_DWR);
      strobe.rd     = (st_q == S_RD);
   end

   assign fl_addr  = (st_q == S_LOAD) ? (base_q | ADDR_W'(idx_q))
                                      : (base_q | ADDR_W'({widx_q, 1'b0}));
   assign buf_init = idle && start && aligned;
   assign buf_upd  = (st_q == S_CAP);
   assign byte_idx = idx_q;
   assign word_idx = widx_q;
   assign busy     = !idle;
   assign done     = done_q;
   assign fail     = fail_q;

endmodule

// File: rtl/fpv_seq.sv
module fpv_seq
   import fpv_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int PAGE_BYTES = 32,
   parameter int T_SETUP    = 4,
   parameter int T_PROG     = 6,
   parameter int T_PHOLD    = 2,
   parameter int T_SHOLD    = 2,
   parameter int T_VON      = 3,
   parameter int T_DUMMY    = 2,
   parameter int T_VOFF     = 2,
   parameter int MAX_TRIES  = 4,
   localparam int IDX_W = $clog2(PAGE_BYTES)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [ADDR_W-1:0] page_addr,
   input  logic              host_we,
   input  logic [IDX_W-1:0]  host_idx,
   input  logic [7:0]        host_data,
   output logic              busy,
   output logic              done,
   output logic              fail,
   output logic              fl_we,
   output logic              fl_setup,
   output logic              fl_prog,
   output logic              fl_verify,
   output logic              fl_wr,
   output logic              fl_rd,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_wdata,
   input  logic [15:0]       fl_rdata
);

   localparam int WIDX_W   = IDX_W - 1;
   localparam int WAIT_MAX = fpv_max(fpv_max(fpv_max(T_SETUP, T_PROG), fpv_max(T_PHOLD, T_SHOLD)),
                                     fpv_max(fpv_max(T_VON, T_DUMMY), T_VOFF));
   localparam int CNT_W    = $clog2(WAIT_MAX + 1);

   // elaboration-time parameter checks
   if (PAGE_BYTES < 4 || (PAGE_BYTES & (PAGE_BYTES - 1)) != 0) begin : g_bad_page
      $error("fpv_seq: PAGE_BYTES must be a power of two, at least 4");
   end
   if (ADDR_W < IDX_W) begin : g_bad_addr
      $error("fpv_seq: ADDR_W too narrow for the page");
   end
   if (T_SETUP < 1 || T_PROG < 1 || T_PHOLD < 1 || T_SHOLD < 1 ||
       T_VON < 1 || T_DUMMY < 1 || T_VOFF < 1) begin : g_bad_wait
      $error("fpv_seq: every wait must be at least one cycle");
   end
   if (MAX_TRIES < 1) begin : g_bad_tries
      $error("fpv_seq: MAX_TRIES must be at least 1");
   end

   logic              tmr_load;
   logic [CNT_W-1:0]  tmr_val;
   logic              tmr_expired;
   logic              buf_init;
   logic              buf_upd;
   logic [IDX_W-1:0]  byte_idx;
   logic [WIDX_W-1:0] word_idx;
   logic [7:0]        rp_byte;
   logic              word_match;
   logic              host_we_g;
   fpv_strobe_t       strobe;

   assign host_we_g = host_we && !busy;

   fpv_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   fpv_buf #(.PAGE_BYTES(PAGE_BYTES)) u_buf (
      .clk        (clk),
      .rst_n      (rst_n),
      .host_we    (host_we_g),
      .host_idx   (host_idx),
      .host_data  (host_data),
      .init       (buf_init),
      .upd        (buf_upd),
      .upd_widx   (word_idx),
      .rdata      (fl_rdata),
      .rd_idx     (byte_idx),
      .rp_byte    (rp_byte),
      .word_match (word_match)
   );

   fpv_ctrl #(
      .ADDR_W     (ADDR_W),
      .PAGE_BYTES (PAGE_BYTES),
      .CNT_W      (CNT_W),
      .T_SETUP    (T_SETUP),
      .T_PROG     (T_PROG),
      .T_PHOLD    (T_PHOLD),
      .T_SHOLD    (T_SHOLD),
      .T_VON      (T_VON),
      .T_DUMMY    (T_DUMMY),
      .T_VOFF     (T_VOFF),
      .MAX_TRIES  (MAX_TRIES)
   ) u_ctrl (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .page_addr   (page_addr),
      .tmr_expired (tmr_expired),
      .word_match  (word_match),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .buf_init    (buf_init),
      .buf_upd     (buf_upd),
      .byte_idx    (byte_idx),
      .word_idx    (word_idx),
      .fl_addr     (fl_addr),
      .strobe      (strobe),
      .busy        (busy),
      .done        (done),
      .fail        (fail)
   );

   assign fl_we     = strobe.we;
   assign fl_setup  = strobe.setup;
   assign fl_prog   = strobe.prog;
   assign fl_verify = strobe.verify;
   assign fl_wr     = strobe.wr;
   assign fl_rd     = strobe.rd;
   assign fl_wdata  = strobe.verify ? 8'hFF : rp_byte;

endmodule

// File: rtl/fpv_seq_chk.sv
module fpv_seq_chk #(
   parameter int ADDR_W = 16,
   parameter int IDX_W  = 5,
   parameter int T_PROG = 6
)(
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [ADDR_W-1:0] page_addr,
   input logic              busy,
   input logic              done,
   input logic              fail,
   input logic              fl_we,
   input logic              fl_setup,
   input logic              fl_prog,
   input logic              fl_verify,
   input logic              fl_wr,
   input logic              fl_rd
);

   int unsigned prog_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       prog_run <= 0;
      else if (fl_prog) prog_run <= prog_run + 1;
      else              prog_run <= 0;
   end

   a_r1_misalign_fail: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && (page_addr[IDX_W-1:0] != '0)) |=> (fail && !busy));

   a_r2_wr_has_we: assert property (@(posedge clk) disable iff (!rst_n)
      fl_wr |-> fl_we);

   a_r4_prog_guard: assert property (@(posedge clk) disable iff (!rst_n)
      fl_prog |-> (fl_setup && fl_we));

   a_r4_verify_excl: assert property (@(posedge clk) disable iff (!rst_n)
      fl_verify |-> (!fl_setup && !fl_prog));

   a_r4_prog_width: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fl_prog) |-> (prog_run == T_PROG));

   a_r5_rd_in_verify: assert property (@(posedge clk) disable iff (!rst_n)
      fl_rd |-> fl_verify);

   a_r7_done_fail_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(done && fail));

   a_r10_status_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (done || fail) |-> (!busy && !fl_we));

   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!fl_we && !fl_wr && !fl_rd && !fl_setup && !fl_verify));

endmodule

bind fpv_seq fpv_seq_chk #(
   .ADDR_W (ADDR_W),
   .IDX_W  (IDX_W),
   .T_PROG (T_PROG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .page_addr (page_addr),
   .busy      (busy),
   .done      (done),
   .fail      (fail),
   .fl_we     (fl_we),
   .fl_setup  (fl_setup),
   .fl_prog   (fl_prog),
   .fl_verify (fl_verify),
   .fl_wr     (fl_wr),
   .fl_rd     (fl_rd)
);

// File: tb/fpv_seq_tb.sv
module fpv_seq_tb;

   localparam int T_SETUP = 4;
   localparam int T_PROG  = 6;
   localparam int MAXT    = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] page_addr = '0;
   logic        host_we = 1'b0;
   logic [4:0]  host_idx = '0;
   logic [7:0]  host_data = '0;
   logic        busy, done, fail;
   logic        fl_we, fl_setup, fl_prog, fl_verify, fl_wr, fl_rd;
   logic [15:0] fl_addr;
   logic [7:0]  fl_wdata;
   logic [15:0] fl_rdata;

   always #5 clk = ~clk;

   fpv_seq #(
      .ADDR_W(16), .PAGE_BYTES(32), .T_SETUP(T_SETUP), .T_PROG(T_PROG),
      .T_PHOLD(2), .T_SHOLD(2), .T_VON(3), .T_DUMMY(2), .T_VOFF(2), .MAX_TRIES(MAXT)
   ) u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .page_addr(page_addr),
      .host_we(host_we), .host_idx(host_idx), .host_data(host_data),
      .busy(busy), .done(done), .fail(fail),
      .fl_we(fl_we), .fl_setup(fl_setup), .fl_prog(fl_prog), .fl_verify(fl_verify),
      .fl_wr(fl_wr), .fl_rd(fl_rd), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
      .fl_rdata(fl_rdata)
   );

   // ---------------- flash model ----------------
   logic       clr = 1'b1;
   int         exp_base = 0;
   int         hard [32];
   logic [7:0] mem [256];
   logic [7:0] lat [32];
   logic [7:0] latlog [8][32];
   int         pc [32][8];
   int         load_pos, addr_err, wr_total, pulses, overpulse;
   int         dummy_cnt, dummy_err, rd_cnt;
   int         prog_run, prog_len, setup_run, setup_lead;
   logic       prog_d;

   always @(posedge clk) begin
      if (clr) begin
         for (int i = 0; i < 256; i++) mem[i] = 8'hFF;
         for (int i = 0; i < 32; i++) begin
            lat[i] = 8'hFF;
            for (int p = 0; p < 8; p++) latlog[p][i] = 8'hFF;
            for (int b = 0; b < 8; b++) pc[i][b] = 0;
         end
         load_pos = 0; addr_err = 0; wr_total = 0; pulses = 0; overpulse = 0;
         dummy_cnt = 0; dummy_err = 0; rd_cnt = 0;
         prog_run = 0; prog_len = 0; setup_run = 0; setup_lead = 0;
         prog_d <= 1'b0;
         fl_rdata <= '0;
      end else begin
         if (fl_wr && !fl_verify) begin
            if (int'(fl_addr) != exp_base + (load_pos % 32)) addr_err++;
            lat[fl_addr[4:0]] = fl_wdata;
            if (pulses < 8) latlog[pulses][fl_addr[4:0]] = fl_wdata;
            load_pos++;
            wr_total++;
         end
         if (fl_wr && fl_verify) begin
            dummy_cnt++;
            if (fl_wdata != 8'hFF || fl_addr[0]) dummy_err++;
         end
         if (fl_rd) begin
            rd_cnt++;
            fl_rdata <= {mem[{fl_addr[7:1], 1'b1}], mem[{fl_addr[7:1], 1'b0}]};
         end
         if (fl_prog && !prog_d) begin
            pulses++;
            setup_lead = setup_run;
            for (int i = 0; i < 32; i++) begin
               for (int b = 0; b < 8; b++) begin
                  if (!lat[i][b]) begin
                     if (!mem[(exp_base & 255) + i][b]) overpulse++;
                     else begin
                        pc[i][b]++;
                        if (pc[i][b] >= hard[i]) mem[(exp_base & 255) + i][b] = 1'b0;
                     end
                  end
               end
            end
         end
         if (fl_prog) prog_run++;
         else if (prog_d) begin prog_len = prog_run; prog_run = 0; end
         if (fl_setup) setup_run++; else setup_run = 0;
         prog_d <= fl_prog;
      end
   end

   // ---------------- bookkeeping ----------------
   int tests = 0;
   int fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp_v);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp_v);
      end
   endtask

   task automatic prep(input int base);
      @(negedge clk);
      exp_base = base;
      for (int i = 0; i < 32; i++) hard[i] = 1;
      clr = 1'b1;
      @(negedge clk);
      clr = 1'b0;
   endtask

   task automatic load(input int idx, input logic [7:0] d);
      @(negedge clk);
      host_we = 1'b1; host_idx = 5'(idx); host_data = d;
      @(negedge clk);
      host_we = 1'b0;
   endtask

   task automatic kick(input logic [15:0] a);
      @(negedge clk);
      start = 1'b1; page_addr = a;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 5000; k++) begin
         if (!busy) break;
         @(negedge clk);
      end
   endtask

   // ---------------- scenarios ----------------
   task automatic t_reset();
      chk(!busy && !done && !fail, "R10", "status after reset", {busy, done, fail}, 0);
      chk(!fl_we && !fl_wr, "R10", "flash strobes after reset", {fl_we, fl_wr}, 0);
   endtask

   task automatic t_misalign();
      prep(16'h1200);
      kick(16'h1205);
      chk(fail && !busy && !done, "R1", "refused start status", {busy, done, fail}, 1);
      repeat (3) @(negedge clk);
      chk(wr_total == 0 && !fl_we, "R1", "no flash activity", wr_total, 0);
   endtask

   task automatic t_partial();
      prep(16'h1220);
      load(0, 8'h12); load(1, 8'h34); load(2, 8'h56); load(3, 8'h78);
      kick(16'h1220);
      chk(busy && fl_we && fl_wr && fl_addr == 16'h1220 && !fail,
          "R2", "first latch write at start+1", int'(fl_addr), 16'h1220);
      chk(!fail && !done, "R10", "start clears fail", {done, fail}, 0);
      wait_idle();
      chk(addr_err == 0 && wr_total == 32, "R2", "ascending latch addresses", addr_err, 0);
      chk(latlog[0][0] == 8'h12 && latlog[0][3] == 8'h78, "R3", "loaded bytes latched",
          int'({latlog[0][0], latlog[0][3]}), 16'h1278);
      chk(latlog[0][4] == 8'hFF && latlog[0][31] == 8'hFF, "R3", "unloaded bytes latched FF",
          int'({latlog[0][4], latlog[0][31]}), 16'hFFFF);
      chk(setup_lead == T_SETUP, "R4", "setup lead before program", setup_lead, T_SETUP);
      chk(prog_len == T_PROG, "R4", "program pulse width", prog_len, T_PROG);
      chk(rd_cnt == 16 && dummy_cnt == 16 && dummy_err == 0, "R5", "verify reads and dummy writes",
          rd_cnt, 16);
      chk(done && !fail && !busy && !fl_we, "R7", "done after one pass", {done, fail, busy}, 4);
      chk(pulses == 1 && mem[8'h23] == 8'h78, "R7", "single pulse, page written", pulses, 1);
   endtask

   task automatic t_slow_bits();
      prep(16'h1240);
      for (int i = 0; i < 32; i++) load(i, (i == 5 || i == 9) ? 8'h00 : 8'(8'hA5 ^ i));
      hard[5] = 3; hard[9] = 2;
      kick(16'h1240);
      wait_idle();
      chk(pulses == 3, "R7", "pulses equal slowest bit", pulses, 3);
      chk(done && !fail, "R7", "slow page completes", {done, fail}, 2);
      chk(overpulse == 0, "R6", "no pulse on a bit reading 0", overpulse, 0);
      chk(latlog[1][0] == 8'hFF && latlog[1][5] == 8'h00 && latlog[1][9] == 8'h00,
          "R6", "second pass keeps only slow bytes",
          int'({latlog[1][0], latlog[1][5], latlog[1][9]}), 24'hFF0000);
      chk(latlog[2][9] == 8'hFF && latlog[2][5] == 8'h00, "R6", "third pass only byte 5",
          int'({latlog[2][9], latlog[2][5]}), 16'hFF00);
      chk(mem[8'h45] == 8'h00 && mem[8'h41] == 8'hA4, "R7", "page contents",
          int'({mem[8'h45], mem[8'h41]}), 16'h00A4);
      chk(rd_cnt == 48, "R5", "one word read per word per pass", rd_cnt, 48);
   endtask

   task automatic t_give_up();
      prep(16'h1260);
      load(0, 8'hFE);
      hard[0] = 99;
      kick(16'h1260);
      wait_idle();
      chk(fail && !done && !fl_we, "R8", "fail after limit", {done, fail, fl_we}, 2);
      chk(pulses == MAXT, "R8", "pulse count at limit", pulses, MAXT);
      repeat (20) @(negedge clk);
      chk(pulses == MAXT && !busy, "R8", "no pulse after fail", pulses, MAXT);
   endtask

   task automatic t_ignore_busy();
      prep(16'h1280);
      kick(16'h1280);
      @(negedge clk);
      host_we = 1'b1; host_idx = 5'd2; host_data = 8'h00;
      start = 1'b1; page_addr = 16'h12A0;
      @(negedge clk);
      host_we = 1'b0; start = 1'b0;
      wait_idle();
      chk(wr_total == 32 && pulses == 1, "R9", "start while busy ignored", wr_total, 32);
      chk(latlog[0][2] == 8'hFF && mem[8'h82] == 8'hFF, "R9", "write while busy not latched",
          int'(latlog[0][2]), 8'hFF);
      repeat (10) @(negedge clk);
      chk(done && !fail, "R10", "done held while idle", {done, fail}, 2);
      prep(16'h12A0);
      kick(16'h12A0);
      chk(!done && busy, "R10", "accepted start clears done", {done, busy}, 1);
      wait_idle();
      chk(latlog[0][2] == 8'hFF && mem[8'hA2] == 8'hFF, "R9", "busy write absent from next op",
          int'(latlog[0][2]), 8'hFF);
   endtask

   initial begin
      for (int i = 0; i < 32; i++) hard[i] = 1;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      clr = 1'b0;
      t_reset();
      t_misalign();
      t_partial();
      t_slow_bits();
      t_give_up();
      t_ignore_busy();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests + 1, fails + 1);
      $finish;
   end

endmodule